// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sets the operating power mode of a chip and turns that mode into enable signals for its subsystems, its CPU and its clock domains. Four modes exist. From highest to lowest power they are full run, reduced run, doze and deep stop. Software enters any mode by writing the mode register while the chip runs. In the two run modes, the per-subsystem enables come from one of two software-written template registers, one template for each run mode. In doze and deep stop, hardware forces every subsystem enable off, whatever the templates hold.

Hardware events bring the chip back from the low-power modes. The wakeup inputs are qualified per mode: doze accepts all six event sources, and deep stop accepts only the port pin event. A qualified wakeup first moves the controller into a settling state. That state holds every subsystem enable off for a programmable number of cycles, and each low-power mode has its own count. After the settling state the controller enters full run. The reset sources are also qualified per mode. A qualified reset returns the controller to full run from any state and restores both templates to all-enabled. A sticky cause register records which qualified wakeup events fired.

Top module: `pwr_mode_seq`

## Requirements
- R1: After `rst_ni` is released, the mode is full run (`mode_o`=00), `sub_en_o` and `clk_en_o` are all ones, `cpu_run_o`=1, `settling_o`=0 and `wake_cause_o`=0. The settle counts take their parameter defaults.
- R2: In either run mode, a write to address 0 sets the mode to `wr_data_i[1:0]` from the next cycle on. The mode codes are 00 full run, 01 reduced run, 10 doze and 11 deep stop, and `mode_o` reports the same code.
- R3: A write to address 0 has no effect while the controller is in doze, in deep stop or in the settling state.
- R4: `sub_en_o` equals the full-run template (address 1) in full run and the reduced-run template (address 2) in reduced run. Bit i of a template enables subsystem i.
- R5: `sub_en_o` is all zeros in doze, in deep stop and in the settling state.
- R6: `cpu_run_o` is 1 in full run and 0 in doze, deep stop and settling. In reduced run it equals bit 2 of the last accepted address-0 write.
- R7: `clk_en_o` is all ones in both run modes. In doze and in settling only bit 0 (the low-speed clock) is set. In deep stop it is all zeros.
- R8: In doze, any set bit of `wake_i` starts settling. The wake bits are: 0 comparator, 1 port pin, 2 bus address match, 3 periodic tick, 4 real-time clock, 5 supply monitor. In the run modes `wake_i` has no effect.
- R9: In deep stop, only `wake_i[1]` starts settling. The other wake bits are ignored.
- R10: Settling lasts S+1 cycles. S is read from address 4 when waking from doze and from address 5 when waking from deep stop. During settling `mode_o` shows the mode being left. The controller then enters full run with the full-run template applied.
- R11: Reset source bits are: 0 external, 1 supply monitor, 2 watchdog, 3 software. Run modes accept all four. Doze and settling accept bits 0 to 2. Deep stop accepts bit 0 only. A source that is not accepted in the current mode has no effect.
- R12: A qualified reset puts the controller in full run on the next cycle and sets both templates to all ones. It wins over any wakeup or register write in the same cycle, and it leaves `wake_cause_o` unchanged.
- R13: `wake_cause_o` ORs in each qualified wakeup bit, in the same bit order as `wake_i`. Writing a one to a bit at address 3 clears that bit. When a set and a clear hit the same bit in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 mode, 1 full-run template, 2 reduced-run template, 3 cause clear, 4 doze settle, 5 deep-stop settle |
| wr_data_i | input | DATA_W | Register write data |
| wake_i | input | 6 | Wakeup event inputs |
| rst_src_i | input | 4 | Reset source inputs |
| sub_en_o | output | N_SUB | Per-subsystem enables |
| cpu_run_o | output | 1 | CPU execution enable |
| clk_en_o | output | CLK_N | Clock domain enables, bit 0 is the low-speed clock |
| mode_o | output | 2 | Current mode code |
| settling_o | output | 1 | High while settling after a wakeup |
| wake_cause_o | output | 6 | Sticky record of qualified wakeup events |

## Verification
The wakeup path is driven with a single source in doze, with every source except the port pin in deep stop, with only the port pin in deep stop, and with all sources in full run. These patterns separate a correct per-mode wake mask from one that is shared or missing. Reset sources are applied one at a time in doze and in deep stop, so an accepted source can be told apart from a rejected one. Simultaneous events check the priority rules: reset against wakeup, reset against a template write, and set against clear in the cause register. Settle counts of 0, 3 and 6 show that the settling length follows the mode being left.

// File: rtl/pms_pkg.sv
package pms_pkg;

   localparam int WAKE_W = 6;
   localparam int RST_W  = 4;

   typedef enum logic [2:0] {
      ST_ACT  = 3'd0,
      ST_ALT  = 3'd1,
      ST_SLP  = 3'd2,
      ST_HIB  = 3'd3,
      ST_WAKE = 3'd4
   } pstate_t;

   localparam logic [1:0] MC_ACT = 2'b00;
   localparam logic [1:0] MC_ALT = 2'b01;
   localparam logic [1:0] MC_SLP = 2'b10;
   localparam logic [1:0] MC_HIB = 2'b11;

   localparam logic [2:0] A_MODE = 3'd0;
   localparam logic [2:0] A_TACT = 3'd1;
   localparam logic [2:0] A_TALT = 3'd2;
   localparam logic [2:0] A_CLR  = 3'd3;
   localparam logic [2:0] A_SSLP = 3'd4;
   localparam logic [2:0] A_SHIB = 3'd5;

   localparam logic [WAKE_W-1:0] WK_MASK_SLP = 6'b111111;
   localparam logic [WAKE_W-1:0] WK_MASK_HIB = 6'b000010;

   localparam logic [RST_W-1:0] RS_MASK_RUN = 4'b1111;
   localparam logic [RST_W-1:0] RS_MASK_SLP = 4'b0111;
   localparam logic [RST_W-1:0] RS_MASK_HIB = 4'b0001;

endpackage

// File: rtl/pms_regs.sv
module pms_regs
   import pms_pkg::*;
#(
   parameter int N_SUB   = 8,
   parameter int CNT_W   = 8,
   parameter int DATA_W  = 16,
   parameter int SLP_RST = 15,
   parameter int HIB_RST = 60
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  pstate_t           state_i,
   input  logic              qrst_i,
   input  logic [WAKE_W-1:0] wake_set_i,
   output logic [N_SUB-1:0]  tpl_act_o,
   output logic [N_SUB-1:0]  tpl_alt_o,
   output logic              alt_cpu_o,
   output logic [CNT_W-1:0]  settle_slp_o,
   output logic [CNT_W-1:0]  settle_hib_o,
   output logic [WAKE_W-1:0] cause_o,
   output logic              mode_wr_o,
   output logic [1:0]        mode_req_o
);

   localparam logic [N_SUB-1:0] TPL_DEF = '1;
   localparam logic [CNT_W-1:0] SLP_DEF = CNT_W'(SLP_RST);
   localparam logic [CNT_W-1:0] HIB_DEF = CNT_W'(HIB_RST);

   logic              wr_ok;
   logic              run_st;
   logic [WAKE_W-1:0] clr_mask;

   assign wr_ok      = wr_en_i && !qrst_i;
   assign run_st     = (state_i == ST_ACT) || (state_i == ST_ALT);
   assign mode_wr_o  = wr_ok && (wr_addr_i == A_MODE) && run_st;
   assign mode_req_o = wr_data_i[1:0];
   assign clr_mask   = (wr_ok && (wr_addr_i == A_CLR)) ? wr_data_i[WAKE_W-1:0] : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tpl_act_o <= TPL_DEF;
         tpl_alt_o <= TPL_DEF;
         alt_cpu_o <= 1'b0;
      end else if (qrst_i) begin
         tpl_act_o <= TPL_DEF;
         tpl_alt_o <= TPL_DEF;
         alt_cpu_o <= 1'b0;
      end else begin
         if (wr_ok && (wr_addr_i == A_TACT)) tpl_act_o <= wr_data_i[N_SUB-1:0];
         if (wr_ok && (wr_addr_i == A_TALT)) tpl_alt_o <= wr_data_i[N_SUB-1:0];
         if (mode_wr_o)                      alt_cpu_o <= wr_data_i[2];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         settle_slp_o <= SLP_DEF;
         settle_hib_o <= HIB_DEF;
      end else begin
         if (wr_ok && (wr_addr_i == A_SSLP)) settle_slp_o <= wr_data_i[CNT_W-1:0];
         if (wr_ok && (wr_addr_i == A_SHIB)) settle_hib_o <= wr_data_i[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cause_o <= '0;
      else         cause_o <= (cause_o & ~clr_mask) | wake_set_i;
   end

endmodule

// File: rtl/pms_qual.sv
module pms_qual
   import pms_pkg::*;
(
   input  pstate_t           state_i,
   input  logic [WAKE_W-1:0] wake_i,
   input  logic [RST_W-1:0]  rst_src_i,
   output logic [WAKE_W-1:0] wake_hit_o,
   output logic              qrst_o
);

   logic [WAKE_W-1:0] wk_mask;
   logic [RST_W-1:0]  rs_mask;

   always_comb begin
      wk_mask = '0;
      rs_mask = RS_MASK_RUN;
      unique case (state_i)
         ST_ACT, ST_ALT: rs_mask = RS_MASK_RUN;
         ST_SLP: begin
            wk_mask = WK_MASK_SLP;
            rs_mask = RS_MASK_SLP;
         end
         ST_HIB: begin
            wk_mask = WK_MASK_HIB;
            rs_mask = RS_MASK_HIB;
         end
         ST_WAKE: rs_mask = RS_MASK_SLP;
         default: rs_mask = RS_MASK_RUN;
      endcase
   end

   assign qrst_o     = |(rst_src_i & rs_mask);
   assign wake_hit_o = qrst_o ? '0 : (wake_i & wk_mask);

endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
   import pms_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             qrst_i,
   input  logic             wake_any_i,
   input  logic             mode_wr_i,
   input  logic [1:0]       mode_req_i,
   input  logic [CNT_W-1:0] settle_slp_i,
   input  logic [CNT_W-1:0] settle_hib_i,
   output pstate_t          state_o,
   output logic [1:0]       origin_o
);

   logic [CNT_W-1:0] cnt_q;
   pstate_t          req_st;

   always_comb begin
      unique case (mode_req_i)
         MC_ACT:  req_st = ST_ACT;
         MC_ALT:  req_st = ST_ALT;
         MC_SLP:  req_st = ST_SLP;
         default: req_st = ST_HIB;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_o  <= ST_ACT;
         cnt_q    <= '0;
         origin_o <= MC_ACT;
      end else if (qrst_i) begin
         state_o  <= ST_ACT;
         cnt_q    <= '0;
         origin_o <= MC_ACT;
      end else begin
         unique case (state_o)
            ST_ACT, ST_ALT: begin
               if (mode_wr_i) state_o <= req_st;
            end
            ST_SLP: begin
               if (wake_any_i) begin
                  state_o  <= ST_WAKE;
                  cnt_q    <= settle_slp_i;
                  origin_o <= MC_SLP;
               end
            end
            ST_HIB: begin
               if (wake_any_i) begin
                  state_o  <= ST_WAKE;
                  cnt_q    <= settle_hib_i;
                  origin_o <= MC_HIB;
               end
            end
            ST_WAKE: begin
               if (cnt_q == '0) begin
                  state_o  <= ST_ACT;
                  origin_o <= MC_ACT;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: state_o <= ST_ACT;
         endcase
      end
   end

endmodule

// File: rtl/pms_outmux.sv
module pms_outmux
   import pms_pkg::*;
#(
   parameter int N_SUB = 8,
   parameter int CLK_N = 3
) (
   input  pstate_t          state_i,
   input  logic [1:0]       origin_i,
   input  logic [N_SUB-1:0] tpl_act_i,
   input  logic [N_SUB-1:0] tpl_alt_i,
   input  logic             alt_cpu_i,
   output logic [N_SUB-1:0] sub_en_o,
   output logic             cpu_run_o,
   output logic [CLK_N-1:0] clk_en_o,
   output logic [1:0]       mode_o,
   output logic             settling_o
);

   logic run_st;
   logic ls_on;

   assign run_st = (state_i == ST_ACT) || (state_i == ST_ALT);
   assign ls_on  = run_st || (state_i == ST_SLP) || (state_i == ST_WAKE);

   always_comb begin
      sub_en_o   = '0;
      cpu_run_o  = 1'b0;
      mode_o     = origin_i;
      settling_o = 1'b0;
      unique case (state_i)
         ST_ACT: begin
            sub_en_o  = tpl_act_i;
            cpu_run_o = 1'b1;
            mode_o    = MC_ACT;
         end
         ST_ALT: begin
            sub_en_o  = tpl_alt_i;
            cpu_run_o = alt_cpu_i;
            mode_o    = MC_ALT;
         end
         ST_SLP:  mode_o = MC_SLP;
         ST_HIB:  mode_o = MC_HIB;
         ST_WAKE: settling_o = 1'b1;
         default: mode_o = MC_ACT;
      endcase
   end

   for (genvar g = 0; g < CLK_N; g++) begin : g_clk
      if (g == 0) begin : g_lowspeed
         assign clk_en_o[g] = ls_on;
      end else begin : g_fast
         assign clk_en_o[g] = run_st;
      end
   end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pms_pkg::*;
#(
   parameter int N_SUB   = 8,
   parameter int CLK_N   = 3,
   parameter int CNT_W   = 8,
   parameter int DATA_W  = 16,
   parameter int SLP_RST = 15,
   parameter int HIB_RST = 60
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [WAKE_W-1:0] wake_i,
   input  logic [RST_W-1:0]  rst_src_i,
   output logic [N_SUB-1:0]  sub_en_o,
   output logic              cpu_run_o,
   output logic [CLK_N-1:0]  clk_en_o,
   output logic [1:0]        mode_o,
   output logic              settling_o,
   output logic [WAKE_W-1:0] wake_cause_o
);

   localparam int CNT_MAX = (1 << CNT_W) - 1;

   if (DATA_W < 8) begin : g_chk_dw
      $error("DATA_W must be at least 8");
   end
   if (N_SUB < 1 || N_SUB > DATA_W) begin : g_chk_nsub
      $error("N_SUB must lie in 1..DATA_W");
   end
   if (CLK_N < 1) begin : g_chk_clk
      $error("CLK_N must be at least 1");
   end
   if (CNT_W < 1 || CNT_W > DATA_W || CNT_W > 24) begin : g_chk_cnt
      $error("CNT_W must lie in 1..min(DATA_W,24)");
   end
   if (SLP_RST < 0 || SLP_RST > CNT_MAX || HIB_RST < 0 || HIB_RST > CNT_MAX) begin : g_chk_rst
      $error("settle defaults must fit in CNT_W bits");
   end

   pstate_t           state;
   logic [1:0]        origin;
   logic              qrst;
   logic [WAKE_W-1:0] wake_hit;
   logic [N_SUB-1:0]  tpl_act;
   logic [N_SUB-1:0]  tpl_alt;
   logic              alt_cpu;
   logic [CNT_W-1:0]  settle_slp;
   logic [CNT_W-1:0]  settle_hib;
   logic              mode_wr;
   logic [1:0]        mode_req;

   pms_qual u_qual (
      .state_i    (state),
      .wake_i     (wake_i),
      .rst_src_i  (rst_src_i),
      .wake_hit_o (wake_hit),
      .qrst_o     (qrst)
   );

   pms_regs #(
      .N_SUB   (N_SUB),
      .CNT_W   (CNT_W),
      .DATA_W  (DATA_W),
      .SLP_RST (SLP_RST),
      .HIB_RST (HIB_RST)
   ) u_regs (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_en_i      (wr_en_i),
      .wr_addr_i    (wr_addr_i),
      .wr_data_i    (wr_data_i),
      .state_i      (state),
      .qrst_i       (qrst),
      .wake_set_i   (wake_hit),
      .tpl_act_o    (tpl_act),
      .tpl_alt_o    (tpl_alt),
      .alt_cpu_o    (alt_cpu),
      .settle_slp_o (settle_slp),
      .settle_hib_o (settle_hib),
      .cause_o      (wake_cause_o),
      .mode_wr_o    (mode_wr),
      .mode_req_o   (mode_req)
   );

   pms_fsm #(
      .CNT_W (CNT_W)
   ) u_fsm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .qrst_i       (qrst),
      .wake_any_i   (|wake_hit),
      .mode_wr_i    (mode_wr),
      .mode_req_i   (mode_req),
      .settle_slp_i (settle_slp),
      .settle_hib_i (settle_hib),
      .state_o      (state),
      .origin_o     (origin)
   );

   pms_outmux #(
      .N_SUB (N_SUB),
      .CLK_N (CLK_N)
   ) u_out (
      .state_i    (state),
      .origin_i   (origin),
      .tpl_act_i  (tpl_act),
      .tpl_alt_i  (tpl_alt),
      .alt_cpu_i  (alt_cpu),
      .sub_en_o   (sub_en_o),
      .cpu_run_o  (cpu_run_o),
      .clk_en_o   (clk_en_o),
      .mode_o     (mode_o),
      .settling_o (settling_o)
   );

endmodule

// File: rtl/pms_chk.sv
module pms_chk
   import pms_pkg::*;
#(
   parameter int N_SUB  = 8,
   parameter int CLK_N  = 3,
   parameter int DATA_W = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_en_i,
   input logic [2:0]        wr_addr_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic [WAKE_W-1:0] wake_i,
   input logic [RST_W-1:0]  rst_src_i,
   input logic [N_SUB-1:0]  sub_en_o,
   input logic              cpu_run_o,
   input logic [CLK_N-1:0]  clk_en_o,
   input logic [1:0]        mode_o,
   input logic              settling_o,
   input logic [WAKE_W-1:0] wake_cause_o
);

   localparam logic [CLK_N-1:0] LS_ONLY = CLK_N'(1);

   p_lowpwr_subs_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settling_o || mode_o[1]) |-> (sub_en_o == '0))
      else $error("R5 subsystem enable set in low-power state");

   p_cpu_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settling_o || mode_o[1]) |-> !cpu_run_o)
      else $error("R6 cpu running in low-power state");

   p_cpu_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b00 && !settling_o) |-> cpu_run_o)
      else $error("R6 cpu stopped in full run");

   p_clk_hib_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b11 && !settling_o) |-> (clk_en_o == '0))
      else $error("R7 clock enabled in deep stop");

   p_clk_doze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b10 && !settling_o) |-> (clk_en_o == LS_ONLY))
      else $error("R7 clock set wrong in doze");

   p_doze_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b10 && !settling_o && wake_i == '0 && rst_src_i[2:0] == 3'b000)
      |=> (mode_o == 2'b10 && !settling_o))
      else $error("R8 doze left without an event");

   p_hib_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b11 && !settling_o && !wake_i[1] && !rst_src_i[0])
      |=> (mode_o == 2'b11 && !settling_o))
      else $error("R9 deep stop left without a qualified event");

   p_settle_exit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!settling_o && $past(settling_o)) |-> (mode_o == 2'b00))
      else $error("R10 settling ended outside full run");

   p_ext_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_src_i[0] |=> (mode_o == 2'b00 && !settling_o))
      else $error("R11 external reset not honoured");

   p_cause_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_addr_i == 3'd3)
      |=> ((wake_cause_o & $past(wake_cause_o)) == $past(wake_cause_o)))
      else $error("R13 cause bit lost without a clear");

endmodule

bind pwr_mode_seq pms_chk #(
   .N_SUB  (N_SUB),
   .CLK_N  (CLK_N),
   .DATA_W (DATA_W)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .wr_en_i      (wr_en_i),
   .wr_addr_i    (wr_addr_i),
   .wr_data_i    (wr_data_i),
   .wake_i       (wake_i),
   .rst_src_i    (rst_src_i),
   .sub_en_o     (sub_en_o),
   .cpu_run_o    (cpu_run_o),
   .clk_en_o     (clk_en_o),
   .mode_o       (mode_o),
   .settling_o   (settling_o),
   .wake_cause_o (wake_cause_o)
);

// File: tb/pwr_mode_seq_tb_top.sv
module pwr_mode_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N_SUB  = 8;
   localparam int CLK_N  = 3;
   localparam int DATA_W = 16;

   localparam int S_MODE = 0, S_SUB = 1, S_CPU = 2, S_CLK = 3, S_CAUSE = 4, S_SET = 5;

   typedef struct {
      int          sel;
      logic [31:0] val;
      string       req;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_ni = 1'b0;
   logic              wr_en = 1'b0;
   logic [2:0]        wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [5:0]        wake = '0;
   logic [3:0]        rst_src = '0;
   logic [N_SUB-1:0]  sub_en;
   logic              cpu_run;
   logic [CLK_N-1:0]  clk_en;
   logic [1:0]        mode;
   logic              settling;
   logic [5:0]        cause;

   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;
   item_t exp_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   pwr_mode_seq dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_ni),
      .wr_en_i      (wr_en),
      .wr_addr_i    (wr_addr),
      .wr_data_i    (wr_data),
      .wake_i       (wake),
      .rst_src_i    (rst_src),
      .sub_en_o     (sub_en),
      .cpu_run_o    (cpu_run),
      .clk_en_o     (clk_en),
      .mode_o       (mode),
      .settling_o   (settling),
      .wake_cause_o (cause)
   );

   function automatic logic [31:0] actual(int sel);
      case (sel)
         S_MODE:  return 32'(mode);
         S_SUB:   return 32'(sub_en);
         S_CPU:   return 32'(cpu_run);
         S_CLK:   return 32'(clk_en);
         S_CAUSE: return 32'(cause);
         default: return 32'(settling);
      endcase
   endfunction

   // monitor: pops and compares expected items away from the active edge
   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         item_t it;
         it = exp_q.pop_front();
         total++;
         if (actual(it.sel) !== it.val) begin
            bad++;
            $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, actual(it.sel), it.val);
         end
      end
   end

   task automatic push(int sel, logic [31:0] v, string r);
      item_t it;
      it.sel = sel;
      it.val = v;
      it.req = r;
      exp_q.push_back(it);
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(logic [2:0] a, logic [DATA_W-1:0] d);
      wr_en = 1'b1;
      wr_addr = a;
      wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic pulse_wake(logic [5:0] v);
      wake = v;
      tick();
      wake = '0;
   endtask

   task automatic pulse_rst(logic [3:0] v);
      rst_src = v;
      tick();
      rst_src = '0;
   endtask

   initial begin
      repeat (3) tick();
      rst_ni = 1'b1;
      // R1 reset state
      push(S_MODE, 0, "R1"); push(S_SUB, 32'hFF, "R1"); push(S_CPU, 1, "R1");
      push(S_CLK, 7, "R1"); push(S_CAUSE, 0, "R1"); push(S_SET, 0, "R1");
      tick();

      // R4 templates
      wr(3'd1, 16'h00A5);
      push(S_SUB, 32'hA5, "R4");
      wr(3'd2, 16'h003C);
      push(S_SUB, 32'hA5, "R4");
      // R2 reduced run, cpu bit clear
      wr(3'd0, 16'h0001);
      push(S_MODE, 1, "R2"); push(S_SUB, 32'h3C, "R4"); push(S_CPU, 0, "R6"); push(S_CLK, 7, "R7");
      wr(3'd0, 16'h0005);
      push(S_MODE, 1, "R2"); push(S_CPU, 1, "R6");
      wr(3'd0, 16'h0000);
      push(S_MODE, 0, "R2"); push(S_SUB, 32'hA5, "R4"); push(S_CPU, 1, "R6");

      wr(3'd4, 16'd3);
      wr(3'd5, 16'd6);

      // R8 wake ignored in full run
      pulse_wake(6'h3F);
      push(S_MODE, 0, "R8"); push(S_SET, 0, "R8"); push(S_CAUSE, 0, "R8");

      // doze
      wr(3'd0, 16'h0002);
      push(S_MODE, 2, "R2"); push(S_SUB, 0, "R5"); push(S_CPU, 0, "R6"); push(S_CLK, 1, "R7");
      wr(3'd0, 16'h0000);
      push(S_MODE, 2, "R3"); push(S_SET, 0, "R3");

      // R8 periodic tick wakes doze, R10 settle 3 -> 4 cycles
      pulse_wake(6'h08);
      push(S_SET, 1, "R8"); push(S_MODE, 2, "R10"); push(S_SUB, 0, "R5");
      push(S_CLK, 1, "R7"); push(S_CPU, 0, "R6"); push(S_CAUSE, 32'h08, "R13");
      repeat (3) tick();
      push(S_SET, 1, "R10");
      tick();
      push(S_SET, 0, "R10"); push(S_MODE, 0, "R10"); push(S_SUB, 32'hA5, "R10");

      // R13 write-one-to-clear
      wr(3'd3, 16'h0001);
      push(S_CAUSE, 32'h08, "R13");
      wr(3'd3, 16'h0008);
      push(S_CAUSE, 0, "R13");

      // R11 software reset rejected in doze, watchdog accepted
      wr(3'd0, 16'h0002);
      pulse_rst(4'b1000);
      push(S_MODE, 2, "R11"); push(S_SET, 0, "R11");
      pulse_rst(4'b0100);
      push(S_MODE, 0, "R11"); push(S_SUB, 32'hFF, "R12"); push(S_CPU, 1, "R12");

      // deep stop
      wr(3'd1, 16'h000F);
      wr(3'd0, 16'h0003);
      push(S_MODE, 3, "R2"); push(S_CLK, 0, "R7"); push(S_SUB, 0, "R5"); push(S_CPU, 0, "R6");
      pulse_wake(6'h3D);
      push(S_MODE, 3, "R9"); push(S_SET, 0, "R9"); push(S_CAUSE, 0, "R9");
      pulse_rst(4'b0110);
      push(S_MODE, 3, "R11"); push(S_SET, 0, "R11");
      pulse_wake(6'h02);
      push(S_SET, 1, "R9"); push(S_MODE, 3, "R10"); push(S_CLK, 1, "R7"); push(S_CAUSE, 32'h02, "R13");
      repeat (6) tick();
      push(S_SET, 1, "R10");
      tick();
      push(S_SET, 0, "R10"); push(S_MODE, 0, "R10"); push(S_SUB, 32'h0F, "R10");

      // R12 reset beats wakeup, cause untouched
      wr(3'd0, 16'h0002);
      wake = 6'h21;
      rst_src = 4'b0001;
      tick();
      wake = '0;
      rst_src = '0;
      push(S_MODE, 0, "R12"); push(S_SET, 0, "R12"); push(S_CAUSE, 32'h02, "R12");
      push(S_SUB, 32'hFF, "R12");

      // R12 reset beats template write in reduced run
      wr(3'd0, 16'h0005);
      push(S_MODE, 1, "R2"); push(S_CPU, 1, "R6"); push(S_SUB, 32'hFF, "R4");
      rst_src = 4'b1000;
      wr(3'd1, 16'h0011);
      rst_src = '0;
      push(S_MODE, 0, "R12"); push(S_SUB, 32'hFF, "R12"); push(S_CPU, 1, "R12");

      // R13 set beats clear
      wr(3'd0, 16'h0002);
      wake = 6'h01;
      wr(3'd3, 16'h0003);
      wake = '0;
      push(S_CAUSE, 32'h01, "R13"); push(S_SET, 1, "R8");
      repeat (3) tick();
      push(S_SET, 1, "R10");
      tick();
      push(S_MODE, 0, "R10"); push(S_SET, 0, "R10");

      // R10 boundary: settle 0 -> one cycle
      wr(3'd4, 16'd0);
      wr(3'd0, 16'h0002);
      pulse_wake(6'h20);
      push(S_SET, 1, "R10"); push(S_CAUSE, 32'h21, "R13");
      tick();
      push(S_MODE, 0, "R10"); push(S_SET, 0, "R10");

      @(negedge clk);
      #1;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule